// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers six event sources into sticky raw flags, gates them with a software enable mask, and merges the enabled, pending flags into one interrupt line and one vector index. The index is an even offset, so a handler can add it straight to a jump-table base. The block reports exactly one source at a time, and it reports the highest-priority enabled source that is pending.

Software has three ways to clear a source. A CPU read of the index clears the source it reports, and the index then moves to the next enabled pending source. Writing ones to the clear port removes the selected raw flags. A read that carries the debug flag returns the same value as a CPU read but changes no state, so a debugger can inspect the controller without disturbing it. When a set event and a clear reach the same flag in the same cycle, the set wins, so no event is dropped.

Top module: `ivec_vector_ctrl`

## Requirements
- R1: After reset the raw flags, the mask, the masked status, the index and the interrupt line are all zero.
- R2: A one on bit k of `evt_set_i` sets raw flag k at the next clock edge. The flag then stays set until a clear or a CPU read removes it.
- R3: `masked_o` equals `raw_o` AND `mask_o`, and `irq_o` is high exactly when `masked_o` is non-zero.
- R4: Bit 0 has the highest priority and bit 5 the lowest. The bits are overflow (0), acquisition done (1), start trigger (2), data ready (3), window high (4) and window low (5). `vec_o` is 2*(k+1) for the lowest-numbered bit k that is set in `masked_o`, which gives the values 2, 4, 6, 8, 10 and 12.
- R5: `vec_o` is 0 when no masked flag is set.
- R6: A CPU read (`vec_rd_i`=1, `vec_rd_dbg_i`=0) clears only the raw flag that `vec_o` reported. From the next cycle `vec_o` shows the next enabled pending source, or 0 if there is none.
- R7: A debug read (`vec_rd_i`=1, `vec_rd_dbg_i`=1) leaves the raw flags and `vec_o` unchanged.
- R8: When `clr_wr_i` is 1, every raw flag whose bit in `clr_wdata_i` is 1 is cleared. Bits written as 0 keep their value. If the reported source is cleared, the index advances.
- R9: If a set event and a clear (written or from a read) hit the same flag in the same cycle, the flag ends up set.
- R10: When `mask_wr_i` is 1, the mask is replaced by `mask_wdata_i`. Changing the mask never changes the raw flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set_i | input | 6 | Per-source set pulses from the event logic |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 6 | New enable mask |
| clr_wr_i | input | 1 | Write-one-to-clear strobe |
| clr_wdata_i | input | 6 | Bits to clear |
| vec_rd_i | input | 1 | Index read strobe |
| vec_rd_dbg_i | input | 1 | Marks the read as coming from the debug port |
| vec_o | output | 4 | Current vector index (read data) |
| raw_o | output | 6 | Raw sticky flags |
| mask_o | output | 6 | Enable mask |
| masked_o | output | 6 | Raw flags AND mask |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach from the ports is a clash in a single cycle, where a CPU read clears the reported source while a set event lands on the same flag or on a different one. The stimulus first builds up several pending sources. It then issues a read in the same cycle as a set pulse and as a write-one-to-clear, and checks that the set survives and that the index moves to the right next source. A full drain of all six sources then shows the whole priority order one read at a time. Debug reads placed between these steps show that nothing moves.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
   localparam int unsigned SRC_OVERFLOW  = 0;
   localparam int unsigned SRC_ACQ_DONE  = 1;
   localparam int unsigned SRC_START     = 2;
   localparam int unsigned SRC_DATA_RDY  = 3;
   localparam int unsigned SRC_WIN_HIGH  = 4;
   localparam int unsigned SRC_WIN_LOW   = 5;

   function automatic int unsigned vec_width(input int unsigned n_src,
                                             input int unsigned step);
      return $clog2(n_src * step + 1);
   endfunction
endpackage

// File: rtl/ivec_flag_bank.sv
module ivec_flag_bank #(
   parameter int unsigned N_SRC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flag_o
);
   logic [N_SRC-1:0] flag_q;
   logic [N_SRC-1:0] flag_d;

   // set dominates clear so no event is lost
   assign flag_d = (flag_q & ~clr_i) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc #(
   parameter int unsigned N_SRC     = 6,
   parameter int unsigned VEC_STEP  = 2,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned IDX_W    = ivec_pkg::vec_width(N_SRC, VEC_STEP)
) (
   input  logic [N_SRC-1:0] req_i,
   output logic [N_SRC-1:0] win_o,
   output logic [IDX_W-1:0] vec_o
);
   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            logic found;
            found = 1'b0;
            win_o = '0;
            vec_o = '0;
            for (int i = 0; i < int'(N_SRC); i++) begin
               if (req_i[i] && !found) begin
                  found    = 1'b1;
                  win_o[i] = 1'b1;
                  vec_o    = IDX_W'((i + 1) * int'(VEC_STEP));
               end
            end
         end
      end else begin : g_msb
         always_comb begin
            logic found;
            found = 1'b0;
            win_o = '0;
            vec_o = '0;
            for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
               if (req_i[i] && !found) begin
                  found    = 1'b1;
                  win_o[i] = 1'b1;
                  vec_o    = IDX_W'((i + 1) * int'(VEC_STEP));
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ivec_clr_ctl.sv
module ivec_clr_ctl #(
   parameter int unsigned N_SRC = 6
) (
   input  logic             clr_wr_i,
   input  logic [N_SRC-1:0] clr_wdata_i,
   input  logic             rd_i,
   input  logic             rd_dbg_i,
   input  logic [N_SRC-1:0] win_i,
   output logic [N_SRC-1:0] clr_o
);
   logic             cpu_rd;
   logic [N_SRC-1:0] sw_clr;
   logic [N_SRC-1:0] rd_clr;

   assign cpu_rd = rd_i & ~rd_dbg_i;
   assign sw_clr = clr_wr_i ? clr_wdata_i : '0;
   assign rd_clr = cpu_rd   ? win_i       : '0;
   assign clr_o  = sw_clr | rd_clr;
endmodule

// File: rtl/ivec_vector_ctrl.sv
module ivec_vector_ctrl #(
   parameter int unsigned N_SRC     = 6,
   parameter int unsigned VEC_STEP  = 2,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned IDX_W    = ivec_pkg::vec_width(N_SRC, VEC_STEP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_set_i,
   input  logic             mask_wr_i,
   input  logic [N_SRC-1:0] mask_wdata_i,
   input  logic             clr_wr_i,
   input  logic [N_SRC-1:0] clr_wdata_i,
   input  logic             vec_rd_i,
   input  logic             vec_rd_dbg_i,
   output logic [IDX_W-1:0] vec_o,
   output logic [N_SRC-1:0] raw_o,
   output logic [N_SRC-1:0] mask_o,
   output logic [N_SRC-1:0] masked_o,
   output logic             irq_o
);
   generate
      if (N_SRC < 1)    begin : g_bad_n    $error("N_SRC must be at least 1");    end
      if (VEC_STEP < 1) begin : g_bad_step $error("VEC_STEP must be at least 1"); end
   endgenerate

   logic [N_SRC-1:0] mask_q;
   logic [N_SRC-1:0] clr_vec;
   logic [N_SRC-1:0] win_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_wr_i) mask_q <= mask_wdata_i;
   end

   ivec_flag_bank #(.N_SRC(N_SRC)) flags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_set_i),
      .clr_i  (clr_vec),
      .flag_o (raw_o)
   );

   assign mask_o   = mask_q;
   assign masked_o = raw_o & mask_q;
   assign irq_o    = |masked_o;

   ivec_prio_enc #(.N_SRC(N_SRC), .VEC_STEP(VEC_STEP), .LSB_FIRST(LSB_FIRST)) enc_i (
      .req_i (masked_o),
      .win_o (win_vec),
      .vec_o (vec_o)
   );

   ivec_clr_ctl #(.N_SRC(N_SRC)) clr_i (
      .clr_wr_i    (clr_wr_i),
      .clr_wdata_i (clr_wdata_i),
      .rd_i        (vec_rd_i),
      .rd_dbg_i    (vec_rd_dbg_i),
      .win_i       (win_vec),
      .clr_o       (clr_vec)
   );
endmodule

// File: rtl/ivec_vector_ctrl_chk.sv
module ivec_vector_ctrl_chk #(
   parameter int unsigned N_SRC = 6,
   parameter int unsigned IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] evt_set_i,
   input logic             mask_wr_i,
   input logic             clr_wr_i,
   input logic             vec_rd_i,
   input logic             vec_rd_dbg_i,
   input logic [IDX_W-1:0] vec_o,
   input logic [N_SRC-1:0] raw_o,
   input logic [N_SRC-1:0] mask_o,
   input logic [N_SRC-1:0] masked_o,
   input logic             irq_o
);
   // R2
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr_i && !vec_rd_i) |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

   // R3
   masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((masked_o & ~raw_o) == '0) && ((masked_o & ~mask_o) == '0));

   // R3
   irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (vec_o != '0));

   // R5
   idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_o == '0) |-> (vec_o == '0));

   // R6
   cpu_read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd_i && !vec_rd_dbg_i && vec_o != '0 && evt_set_i == '0 && !mask_wr_i)
      |=> (vec_o != $past(vec_o)));

   // R7
   dbg_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd_i && vec_rd_dbg_i && evt_set_i == '0 && !clr_wr_i && !mask_wr_i)
      |=> ($stable(raw_o) && $stable(vec_o)));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set_i != '0) |=> ((raw_o & $past(evt_set_i)) == $past(evt_set_i)));
endmodule

bind ivec_vector_ctrl ivec_vector_ctrl_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .evt_set_i    (evt_set_i),
   .mask_wr_i    (mask_wr_i),
   .clr_wr_i     (clr_wr_i),
   .vec_rd_i     (vec_rd_i),
   .vec_rd_dbg_i (vec_rd_dbg_i),
   .vec_o        (vec_o),
   .raw_o        (raw_o),
   .mask_o       (mask_o),
   .masked_o     (masked_o),
   .irq_o        (irq_o)
);

// File: tb/ivec_vector_ctrl_tb_top.sv
module ivec_vector_ctrl_tb_top;
   localparam int N = 6;

   typedef struct {
      string    req;
      logic [5:0] raw;
      logic [5:0] mask;
      logic [3:0] vec;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt_set = '0;
   logic       mask_wr = 1'b0;
   logic [5:0] mask_wdata = '0;
   logic       clr_wr = 1'b0;
   logic [5:0] clr_wdata = '0;
   logic       rd = 1'b0;
   logic       rd_dbg = 1'b0;
   logic [3:0] vec;
   logic [5:0] raw, mask, masked;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t sb_q[$];
   logic [5:0] m_raw = '0;
   logic [5:0] m_mask = '0;

   always #2.5 clk = ~clk;

   ivec_vector_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set),
      .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
      .clr_wr_i(clr_wr), .clr_wdata_i(clr_wdata),
      .vec_rd_i(rd), .vec_rd_dbg_i(rd_dbg),
      .vec_o(vec), .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq)
   );

   function automatic logic [3:0] model_vec(input logic [5:0] r, input logic [5:0] m);
      for (int i = 0; i < N; i++)
         if (r[i] && m[i]) return 4'((i + 1) * 2);
      return 4'd0;
   endfunction

   task automatic check(input string req, input logic [5:0] er, input logic [5:0] em,
                        input logic [3:0] ev);
      logic [5:0] emk;
      emk = er & em;
      checks++;
      if (raw !== er || mask !== em || masked !== emk || vec !== ev || irq !== (emk != 0)) begin
         fails++;
         $display("FAIL %s: raw=%h mask=%h masked=%h vec=%0d irq=%b exp raw=%h mask=%h masked=%h vec=%0d irq=%b",
                  req, raw, mask, masked, vec, irq, er, em, emk, ev, emk != 0);
      end
   endtask

   // driver: applies one cycle of stimulus and pushes the expected result
   task automatic step(input string req, input logic [5:0] s, input bit mw, input logic [5:0] md,
                       input bit cw, input logic [5:0] cd, input bit r, input bit dbg);
      logic [5:0] clr;
      exp_t e;
      @(negedge clk);
      evt_set = s; mask_wr = mw; mask_wdata = md; clr_wr = cw; clr_wdata = cd;
      rd = r; rd_dbg = dbg;
      clr = cw ? cd : 6'h0;
      if (r && !dbg && model_vec(m_raw, m_mask) != 0)
         clr |= 6'(1 << (model_vec(m_raw, m_mask) / 2 - 1));
      @(posedge clk);
      #1;
      m_raw = (m_raw & ~clr) | s;
      if (mw) m_mask = md;
      e.req = req; e.raw = m_raw; e.mask = m_mask; e.vec = model_vec(m_raw, m_mask);
      sb_q.push_back(e);
      @(negedge clk);
      evt_set = '0; mask_wr = 0; clr_wr = 0; rd = 0; rd_dbg = 0;
   endtask

   // monitor: pops expected items and compares away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, e.raw, e.mask, e.vec);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 6'h00, 6'h00, 4'd0);
      rst_n = 1'b1;
      // R2 R5: data ready pending, nothing enabled
      step("R2", 6'b001000, 0, 0, 0, 0, 0, 0);
      step("R5", 6'b000000, 0, 0, 0, 0, 0, 0);
      // R10 R3: enable all
      step("R10", 6'b000000, 1, 6'h3F, 0, 0, 0, 0);
      // R4: window low and acquisition done arrive
      step("R4", 6'b100010, 0, 0, 0, 0, 0, 0);
      // R7: debug read changes nothing
      step("R7", 6'b000000, 0, 0, 0, 0, 1, 1);
      // R6: CPU reads advance 4 -> 8 -> 12
      step("R6", 6'b000000, 0, 0, 0, 0, 1, 0);
      step("R6", 6'b000000, 0, 0, 0, 0, 1, 0);
      // R10: masking hides but keeps raw
      step("R10", 6'b000000, 1, 6'b011111, 0, 0, 0, 0);
      step("R3", 6'b000000, 1, 6'h3F, 0, 0, 0, 0);
      // R8: write-one-to-clear, zeros have no effect
      step("R8", 6'b000000, 0, 0, 1, 6'b100000, 0, 0);
      // R9: set and clear same flag
      step("R9", 6'b000001, 0, 0, 1, 6'b000001, 0, 0);
      // R9 R6: read clears overflow while start trigger is set
      step("R9", 6'b000100, 0, 0, 0, 0, 1, 0);
      // R8: clearing the reported source advances index
      step("R8", 6'b011000, 0, 0, 0, 0, 0, 0);
      step("R8", 6'b000000, 0, 0, 1, 6'b000100, 0, 0);
      // R5 R6: drain then read empty
      step("R8", 6'b000000, 0, 0, 1, 6'h3F, 0, 0);
      step("R5", 6'b000000, 0, 0, 0, 0, 1, 0);
      // R4: full priority drain
      step("R2", 6'h3F, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < N; k++) step("R4", 6'b000000, 0, 0, 0, 0, 1, 0);
      // R7: debug read after raw set but masked-off highest
      step("R7", 6'b000011, 1, 6'b000010, 0, 0, 1, 1);
      step("R7", 6'b000000, 0, 0, 0, 0, 1, 1);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule